// File: doc/BRIEF.md
# PHY Management Bus Command Controller

This block lets a host reach the management registers of an attached Ethernet PHY through three 16-bit registers. The host first puts any value to be written into the write-data register. It then writes a command word that names the PHY, the register inside that PHY and the direction of the access. The block runs one clause-22 management frame on the serial clock and data pins. While the frame runs, the direction bit in the command word stays set. The hardware clears that bit when the frame ends, and the host polls it to learn when the access is complete. For a read, the host then collects the result from the read-data register.

The serial clock comes from the system clock through a divider whose half period is the parameter `DIV_HALF`. The serial clock runs only while a frame is in progress and rests low at all other times. The data pin is split into an output value, an output enable and an input. This lets the pad ring place the tri-state buffer.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command, write-data and read-data registers all read 0, and `mdc` and `mdio_oe` are low.
- R2: The command word (select 0) uses bits 4:0 for the register number, bits 12:8 for the PHY address, bit 13 to request a read and bit 14 to request a write. Bits 15 and 7:5 read as 0. A write to this word while idle stores the fields. If bit 13 or bit 14 is set, the write also starts a frame, and the stored request bits stay visible until the frame ends. If both bits are set, the block performs a write.
- R3: While a frame runs, `mdc` has a period of 2*DIV_HALF system clocks and starts with its low half. It rises DIV_HALF cycles after the clock edge that accepts the command. Outside a frame, `mdc` is low.
- R4: A frame has 64 bit slots. In order they are: 32 ones, then 0 and 1, then the opcode (1,0 for a read or 0,1 for a write), then the PHY address MSB first, then the register number MSB first. For a write, these are followed by 1 and 0 and then the 16 data bits MSB first. Slot k occupies cycles 2*DIV_HALF*k through 2*DIV_HALF*(k+1)-1 after the accepting edge, and `mdio_o` changes only at a falling transition of `mdc`.
- R5: In a read, `mdio_oe` is low for slots 46 to 63. `mdio_i` is sampled on each rising `mdc` in slots 48 to 63, MSB first. The 16 sampled bits appear in the read-data register (select 2) when the frame ends.
- R6: The request bits clear, and `mdio_oe` and `mdc` are low, 128*DIV_HALF cycles after the accepting edge. `mdio_oe` is never high outside a frame.
- R7: A write to the command word during a frame is ignored. The stored fields and the frame on the pins stay as they were.
- R8: The write-data register (select 1) may be written and read back at any time. A frame sends the value that the register held when the command was accepted.
- R9: A write frame leaves the read-data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host write strobe for the selected register |
| host_addr | input | 2 | Register select: 0 command, 1 write data, 2 read data |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Selected register contents (combinational) |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Management data from the pad |

## Verification
All timing in the bench counts from the clock edge that accepts a command. The clock rises at cycle DIV_HALF and then toggles every DIV_HALF cycles. Slot k of the frame lasts from cycle 2*DIV_HALF*k to cycle 2*DIV_HALF*(k+1)-1. The request bits clear at cycle 128*DIV_HALF. The bench counts cycles from that edge with its own integer, works out the expected clock level, enable, data bit and command readback for each cycle, and compares them on the falling system-clock edge of that cycle. The simulated PHY changes `mdio_i` only on falling system-clock edges inside each slot, so the value is steady when the block samples it half a slot later. The read-data and write-data registers are checked one cycle after the frame ends.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the PHY management controller.
// Assumes a clause-22 frame with a 32-bit preamble and 16-bit data.
package mdio_pkg;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int RD_BIT     = 13;
    localparam int WR_BIT     = 14;
    localparam int PHY_LSB    = 8;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_WDATA = 2'd1,
        SEL_RDATA = 2'd2
    } host_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regn;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
// Serial clock divider. While run is high, the clock toggles every DIV_HALF
// system cycles, starting from low. Single-cycle ticks mark the rising and
// falling transitions. Assumes DIV_HALF >= 1; the clock is held low when run is low.
module mdio_clk_div #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             half_end;

    assign half_end  = run && (cnt_q == CNT_LAST);
    assign rise_tick = half_end && !mdc_q;
    assign fall_tick = half_end && mdc_q;
    assign mdc       = mdc_q;

    // Count half periods and toggle the serial clock at the end of each one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            cnt_q <= half_end ? '0 : cnt_q + 1'b1;
            if (half_end) mdc_q <= !mdc_q;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer. On start, it loads the whole 64-slot frame into a shift
// register and shifts one slot out at each falling tick. In a read, it
// releases the pad from the turnaround onward and shifts in data on rising
// ticks. Assumes start is raised only while it is idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_result,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(TA_POS + 2);

    logic [FRAME_BITS-1:0] shift_q;
    logic [FRAME_BITS-1:0] frame_load;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q;
    logic                  rd_op_q;
    logic [DATA_W-1:0]     rx_q;
    logic                  unused_rd_flag;

    assign unused_rd_flag = cmd.rd;

    // Build the complete frame for the command being accepted.
    always_comb begin
        frame_load = {{PRE_BITS{1'b1}}, 2'b01,
                      (cmd.wr ? 2'b01 : 2'b10),
                      cmd.phy, cmd.regn,
                      (cmd.wr ? 2'b10 : 2'b11),
                      (cmd.wr ? wdata : {DATA_W{1'b1}})};
    end

    // Advance through the frame one slot per serial clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            shift_q <= '0;
            rd_op_q <= 1'b0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            shift_q <= frame_load;
            rd_op_q <= !cmd.wr;
        end else if (busy_q && fall_tick) begin
            if (idx_q == LAST_IDX) begin
                busy_q <= 1'b0;
            end else begin
                idx_q   <= idx_q + 1'b1;
                shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Capture read data on the rising serial clock, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (busy_q && rise_tick && rd_op_q && idx_q >= DATA_IDX) begin
            rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
    end

    assign busy      = busy_q;
    assign done      = busy_q && fall_tick && (idx_q == LAST_IDX);
    assign rd_result = rx_q;
    assign mdio_o    = shift_q[FRAME_BITS-1];
    assign mdio_oe   = busy_q && !(rd_op_q && idx_q >= TA_IDX);

    // Count falling ticks in the current frame; used only by the checks below.
    logic [IDX_W:0] fall_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !busy_q)) fall_cnt_q <= '0;
        else if (busy_q && fall_tick)     fall_cnt_q <= fall_cnt_q + 1'b1;
    end

    // R4
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fall_tick) |=> $stable(mdio_o));

    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (fall_cnt_q == (IDX_W+1)'(FRAME_BITS)));

    // R5
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tick && rd_op_q && idx_q >= DATA_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mdio_host_regs.sv
// Host register file. It decodes writes to the command, write-data and
// read-data selects. A command write that carries a request bit and
// arrives while idle starts a frame. The request bits clear on done.
// Assumes a single-cycle write strobe and a combinational read.
module mdio_host_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_result,
    output logic [DATA_W-1:0] host_rdata,
    output logic              start,
    output mdio_cmd_t         start_cmd,
    output logic [DATA_W-1:0] wdata
);
    mdio_cmd_t         cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              cmd_hit;
    logic              unused_bits;

    assign unused_bits = ^{host_wdata[15], host_wdata[7:5]};
    assign cmd_hit     = host_we && (host_addr == SEL_CMD);
    assign start_cmd   = '{wr:   host_wdata[WR_BIT],
                           rd:   host_wdata[RD_BIT],
                           phy:  host_wdata[PHY_LSB +: PHY_W],
                           regn: host_wdata[REG_W-1:0]};
    assign start       = cmd_hit && !busy && (start_cmd.wr || start_cmd.rd);
    assign wdata       = wdata_q;

    // Store the command fields while idle and clear the request bits on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_hit && !busy) begin
            cmd_q <= start_cmd;
        end else if (done) begin
            cmd_q.wr <= 1'b0;
            cmd_q.rd <= 1'b0;
        end
    end

    // Accept write data from the host at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wdata_q <= '0;
        else if (host_we && host_addr == SEL_WDATA) wdata_q <= host_wdata;
    end

    // Load the read result when a read frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)               rdata_q <= '0;
        else if (done && !cmd_q.wr) rdata_q <= rd_result;
    end

    // Return the selected register to the host.
    always_comb begin
        case (host_addr)
            SEL_CMD:   host_rdata = {1'b0, cmd_q.wr, cmd_q.rd, cmd_q.phy, 3'b000, cmd_q.regn};
            SEL_WDATA: host_rdata = wdata_q;
            SEL_RDATA: host_rdata = rdata_q;
            default:   host_rdata = '0;
        endcase
    end

    // R7
    busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy) |=> ($stable(cmd_q.phy) && $stable(cmd_q.regn)));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q.wr) |=> $stable(rdata_q));
endmodule

// File: rtl/mdio_cmd_ctrl.sv
// Top level of the PHY management command controller. It connects the host
// registers, the frame sequencer and the serial clock divider. The clock
// runs only while a frame is in progress. Assumes the pad combines mdio_o
// and mdio_oe into a tri-state buffer.
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy;
    logic              done;
    logic              start;
    logic              rise_tick;
    logic              fall_tick;
    mdio_cmd_t         start_cmd;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_result;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .done       (done),
        .rd_result  (rd_result),
        .host_rdata (host_rdata),
        .start      (start),
        .start_cmd  (start_cmd),
        .wdata      (wdata)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (start_cmd),
        .wdata     (wdata),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rd_result (rd_result),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R6
    oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
// Bench with a behavioural per-cycle model of the frame, the serial clock and the register readback.
module mdio_cmd_ctrl_bench;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_we;
    logic [1:0]  host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] model_rdata = 16'h0;

    always #10 clk = ~clk;

    mdio_cmd_ctrl #(.DIV_HALF(H)) u_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [15:0] val);
        @(negedge clk);
        host_we = 1'b0; host_addr = sel;
        #1 val = host_rdata;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        host_we = 1'b1; host_addr = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // inj_kind: 0 none, 1 command write during frame, 2 write-data write during frame
    task automatic run_txn(input bit is_wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] phy_data,
                           input int inj_kind, input int inj_n);
        bit fr[$];
        logic [15:0] cmdw, v;
        int k;
        bit exp_oe;
        write_reg(2'd1, wd);
        repeat (32) fr.push_back(1'b1);
        fr.push_back(1'b0); fr.push_back(1'b1);
        if (is_wr) begin fr.push_back(1'b0); fr.push_back(1'b1); end
        else       begin fr.push_back(1'b1); fr.push_back(1'b0); end
        for (int i = 4; i >= 0; i--) fr.push_back(phy[i]);
        for (int i = 4; i >= 0; i--) fr.push_back(rg[i]);
        fr.push_back(1'b1); fr.push_back(1'b0);
        for (int i = 15; i >= 0; i--) fr.push_back(wd[i]);
        cmdw = (is_wr ? 16'h4000 : 16'h2000) | {3'b000, phy, 8'h00} | {11'h0, rg};
        @(negedge clk);
        host_we = 1'b1; host_addr = 2'd0; host_wdata = cmdw;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n <= 128 * H; n++) begin
            k = n / (2 * H);
            host_we = 1'b0; host_addr = 2'd0;
            mdio_i = (!is_wr && k >= 48 && k < 64) ? phy_data[63 - k] : 1'b1;
            if (n == inj_n && inj_kind == 1) begin
                host_we = 1'b1; host_wdata = 16'h6507;
            end else if (n == inj_n && inj_kind == 2) begin
                host_we = 1'b1; host_addr = 2'd1; host_wdata = 16'h1234;
            end
            #1;
            if (n < 128 * H) begin
                exp_oe = !( !is_wr && k >= 46);
                chk("R3 mdc level", {15'h0, mdc}, {15'h0, ((n / H) % 2) == 1});
                chk(is_wr ? "R4 mdio_oe" : "R5 mdio_oe", {15'h0, mdio_oe}, {15'h0, exp_oe});
                if (exp_oe) chk("R4 mdio_o slot", {15'h0, mdio_o}, {15'h0, fr[k]});
                if (host_addr == 2'd0) chk("R2 R7 cmd readback busy", host_rdata, cmdw);
            end else begin
                chk("R6 mdc low at end", {15'h0, mdc}, 16'h0);
                chk("R6 oe low at end", {15'h0, mdio_oe}, 16'h0);
                chk("R6 request cleared", host_rdata, cmdw & 16'h1F1F);
            end
            @(posedge clk);
            @(negedge clk);
        end
        host_we = 1'b0;
        if (!is_wr) model_rdata = phy_data;
        read_reg(2'd2, v);
        chk(is_wr ? "R9 rdata kept" : "R5 rdata result", v, model_rdata);
        read_reg(2'd1, v);
        chk("R8 wdata readback", v, (inj_kind == 2) ? 16'h1234 : wd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_wdata = 16'h0; mdio_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        read_reg(2'd0, v); chk("R1 cmd reset", v, 16'h0);
        read_reg(2'd1, v); chk("R1 wdata reset", v, 16'h0);
        read_reg(2'd2, v); chk("R1 rdata reset", v, 16'h0);
        chk("R1 mdc reset", {15'h0, mdc}, 16'h0);
        chk("R1 oe reset", {15'h0, mdio_oe}, 16'h0);
        // R2: a command without a request bit stores fields, starts nothing
        write_reg(2'd0, 16'hFFFF & 16'h9FFF);
        for (int i = 0; i < 2 * H + 4; i++) begin
            @(negedge clk); #1;
            chk("R2 R3 no start mdc", {15'h0, mdc}, 16'h0);
            chk("R2 R6 no start oe", {15'h0, mdio_oe}, 16'h0);
        end
        read_reg(2'd0, v); chk("R2 fields only", v, 16'h1F1F);
        // Write frames and read frames with boundary fields and data
        run_txn(1'b1, 5'd1, 5'd4, 16'hA5C3, 16'h0, 0, -1);
        run_txn(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000, 1, 40);
        run_txn(1'b0, 5'd31, 5'd31, 16'h0F0F, 16'h8001, 1, 128 * H - 2);
        run_txn(1'b1, 5'd26, 5'd5, 16'hFFFF, 16'h0, 2, 100);
        run_txn(1'b0, 5'd3, 5'd17, 16'h0000, 16'h5A5A, 0, -1);
        run_txn(1'b1, 5'd31, 5'd0, 16'h0000, 16'h0, 0, -1);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule